// File: doc/BRIEF.md
# Per-Bank Round-Robin Request Arbiter With Master Locks

This block sits between a set of requesting masters and the per-bank command queues of a DRAM controller. Each master offers one command at a time: a valid flag, a write flag and an address. A fixed field of the address picks the target bank. Every bank has its own round-robin arbiter over all masters. The granted command goes to the bank, and the bank's ready goes back to the granted master.

A bank may raise its lock input while it serves a multi-beat transaction. While the lock is up, the bank keeps its current grant. That master is also barred from every other bank, so a transaction can never be split across two banks. Write-data-ready and read-data-valid strobes from each bank go back to the master that the bank grants in that cycle. They pass through a fixed delay of `LAT` cycles so that they line up with the separate data path.

Top module: `bank_rr_xbar`

## Requirements
- R1: A master's target bank is address bits [BLSB+BB-1:BLSB] (bits [6:4] with default parameters). When a bank's `b_valid` is 1, its `b_addr` and `b_we` equal the address and write flag of the master it grants, and that address decodes to this bank.
- R2: A master is a candidate for a bank only when its `m_valid` is 1, its address decodes to that bank, and it is not held by another bank. A bank with no candidate and no held grant drives `b_valid` 0.
- R3: A bank holds its grant when it granted a master in the previous cycle and its `b_lock` is 1 now. A held master gets no grant and no ready from any other bank, even when it addresses one.
- R4: While a bank's `b_lock` stays 1, its grant stays on the same master, even if another master makes a valid request to that bank. It re-arbitrates in the first cycle in which the lock is 0.
- R5: Round-robin order: after master i is accepted by a bank, that bank searches from master (i+1) mod M upward. After reset every bank starts its search at master 0.
- R6: The priority pointer of a bank moves only when a command is accepted (`b_valid` and `b_ready` both 1). A stalled grant therefore stays with the same master.
- R7: `m_ready[m]` is the `b_ready` of the bank that grants master m with a valid command for that bank, and 0 when no bank does so.
- R8: `m_wdata_ready[m]` and `m_rdata_valid[m]` equal the OR, over all banks that grant master m in a cycle, of those banks' `b_wdata_ready` and `b_rdata_valid`, delayed by exactly `LAT` cycles (default 2).
- R9: After reset no bank holds a grant, no strobe is pending, and with no valid request all of `b_valid`, `m_ready`, `m_wdata_ready` and `m_rdata_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | NM | Per-master command valid |
| m_we | input | NM | Per-master write flag |
| m_addr | input | NM*AW | Per-master address, master m at bits [m*AW +: AW] |
| m_ready | output | NM | Per-master command accepted |
| m_wdata_ready | output | NM | Delayed write-data-ready strobe per master |
| m_rdata_valid | output | NM | Delayed read-data-valid strobe per master |
| b_valid | output | NB | Per-bank forwarded command valid |
| b_we | output | NB | Per-bank forwarded write flag |
| b_addr | output | NB*AW | Per-bank forwarded address, bank b at bits [b*AW +: AW] |
| b_ready | input | NB | Per-bank command accept |
| b_lock | input | NB | Per-bank transaction lock |
| b_wdata_ready | input | NB | Per-bank write-data-ready strobe |
| b_rdata_valid | input | NB | Per-bank read-data-valid strobe |

## Verification
The assertions place no protocol limits on the bank side. Lock, ready and the strobes may change in any cycle, and the properties hold for any such pattern. What they assume is that all inputs carry known values once reset is released. The number of masters must be a power of two, so that the grant index covers the masters exactly. The stimulus keeps every input at 0 or 1 on every cycle. It drives lock high only about a third of the time, so held grants are released often and arbitration keeps moving. Most random addresses fall in four banks, which forces contention.

// File: rtl/bank_rr_xbar.sv
module bank_rr_xbar #(
  parameter int NM   = 4,
  parameter int NB   = 8,
  parameter int BB   = 3,
  parameter int AW   = 16,
  parameter int BLSB = 4,
  parameter int LAT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    m_valid,
  input  logic [NM-1:0]    m_we,
  input  logic [NM*AW-1:0] m_addr,
  output logic [NM-1:0]    m_ready,
  output logic [NM-1:0]    m_wdata_ready,
  output logic [NM-1:0]    m_rdata_valid,
  output logic [NB-1:0]    b_valid,
  output logic [NB-1:0]    b_we,
  output logic [NB*AW-1:0] b_addr,
  input  logic [NB-1:0]    b_ready,
  input  logic [NB-1:0]    b_lock,
  input  logic [NB-1:0]    b_wdata_ready,
  input  logic [NB-1:0]    b_rdata_valid
);
  localparam int MW = (NM > 1) ? $clog2(NM) : 1;

  logic [BB-1:0] mbank   [NM];
  logic [NM-1:0] cand    [NB];
  logic [NB-1:0] acc     [NM];
  logic [MW-1:0] owner_q [NB];
  logic [MW-1:0] ptr_q   [NB];
  logic [MW-1:0] gidx    [NB];
  logic [NB-1:0] ownv_q, hold, gv, eff;
  logic [NM-1:0] rw, rv;

  always_comb
    for (int m = 0; m < NM; m++) mbank[m] = m_addr[m*AW+BLSB +: BB];

  assign hold = ownv_q & b_lock;

  // candidate filter: valid, bank match, not held elsewhere
  always_comb begin
    logic blk;
    for (int b = 0; b < NB; b++)
      for (int m = 0; m < NM; m++) begin
        blk = 1'b0;
        for (int b2 = 0; b2 < NB; b2++)
          if (b2 != b && hold[b2] && owner_q[b2] == MW'(m)) blk = 1'b1;
        cand[b][m] = m_valid[m] && (mbank[m] == BB'(b)) && !blk;
      end
  end

  // round-robin pick from the pointer, held grant wins
  always_comb begin
    logic          found;
    logic [MW-1:0] pick;
    int            idx;
    for (int b = 0; b < NB; b++) begin
      found = 1'b0;
      pick  = ptr_q[b];
      for (int k = 0; k < NM; k++) begin
        idx = (int'(ptr_q[b]) + k) % NM;
        if (!found && cand[b][idx]) begin
          found = 1'b1;
          pick  = MW'(idx);
        end
      end
      gidx[b] = hold[b] ? owner_q[b] : pick;
      gv[b]   = hold[b] | found;
      eff[b]  = gv[b] && m_valid[gidx[b]] && (mbank[gidx[b]] == BB'(b));
    end
  end

  assign b_valid = eff;

  always_comb
    for (int b = 0; b < NB; b++) begin
      b_we[b]            = m_we[gidx[b]];
      b_addr[b*AW +: AW] = m_addr[gidx[b]*AW +: AW];
    end

  always_comb begin
    m_ready = '0;
    rw      = '0;
    rv      = '0;
    for (int m = 0; m < NM; m++) begin
      for (int b = 0; b < NB; b++) begin
        acc[m][b] = eff[b] && gidx[b] == MW'(m);
        if (acc[m][b] && b_ready[b]) m_ready[m] = 1'b1;
        if (gv[b] && gidx[b] == MW'(m)) begin
          rw[m] = rw[m] | b_wdata_ready[b];
          rv[m] = rv[m] | b_rdata_valid[b];
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (!rst_n)
      for (int b = 0; b < NB; b++) begin
        owner_q[b] <= '0;
        ptr_q[b]   <= '0;
        ownv_q[b]  <= 1'b0;
      end
    else
      for (int b = 0; b < NB; b++) begin
        owner_q[b] <= gidx[b];
        ownv_q[b]  <= gv[b];
        if (eff[b] && b_ready[b])
          ptr_q[b] <= (gidx[b] == MW'(NM-1)) ? '0 : gidx[b] + 1'b1;
      end

  generate
    if (LAT == 0) begin : g_nodly
      assign m_wdata_ready = rw;
      assign m_rdata_valid = rv;
    end else begin : g_dly
      logic [NM-1:0] wp [LAT];
      logic [NM-1:0] rp [LAT];
      always_ff @(posedge clk)
        if (!rst_n)
          for (int i = 0; i < LAT; i++) begin
            wp[i] <= '0;
            rp[i] <= '0;
          end
        else begin
          wp[0] <= rw;
          rp[0] <= rv;
          for (int i = 1; i < LAT; i++) begin
            wp[i] <= wp[i-1];
            rp[i] <= rp[i-1];
          end
        end
      assign m_wdata_ready = wp[LAT-1];
      assign m_rdata_valid = rp[LAT-1];
    end
  endgenerate

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank_chk
      a_r1_bank_field: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid[b] |-> b_addr[b*AW+BLSB +: BB] == BB'(b));
      a_r4_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (gv[b] && b_lock[b]) |=> (!b_lock[b] || (gv[b] && gidx[b] == $past(gidx[b]))));
      a_r6_ptr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_valid[b] && b_ready[b]) |=> $stable(ptr_q[b]));
    end
    for (genvar m = 0; m < NM; m++) begin : g_mst_chk
      a_r3_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc[m]));
      a_r7_ready_valid: assert property (@(posedge clk) disable iff (!rst_n)
        m_ready[m] |-> m_valid[m]);
    end
  endgenerate
endmodule

// File: tb/tb_bank_rr_xbar.sv
`timescale 1ns/1ps
module tb_bank_rr_xbar;
  localparam int NM = 4, NB = 8, BB = 3, AW = 16, BLSB = 4, LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NM-1:0] m_valid = '0, m_we = '0;
  logic [NM*AW-1:0] m_addr = '0;
  logic [NB-1:0] b_ready = '0, b_lock = '0, b_wdata_ready = '0, b_rdata_valid = '0;
  logic [NM-1:0] m_ready, m_wdata_ready, m_rdata_valid;
  logic [NB-1:0] b_valid, b_we;
  logic [NB*AW-1:0] b_addr;

  bank_rr_xbar #(.NM(NM), .NB(NB), .BB(BB), .AW(AW), .BLSB(BLSB), .LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr),
    .m_ready(m_ready), .m_wdata_ready(m_wdata_ready), .m_rdata_valid(m_rdata_valid),
    .b_valid(b_valid), .b_we(b_we), .b_addr(b_addr), .b_ready(b_ready), .b_lock(b_lock),
    .b_wdata_ready(b_wdata_ready), .b_rdata_valid(b_rdata_valid));

  int nchk = 0, nfail = 0;
  bit done = 0;

  int own [NB], ptr [NB], g [NB];
  bit ov [NB], gv [NB], ef [NB];
  logic [NM-1:0] e_rdy, e_rw, e_rv;
  logic [NM-1:0] hw [LAT], hr [LAT];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int mb(int m);
    return int'(m_addr[m*AW+BLSB +: BB]);
  endfunction

  task automatic set_req(int m, bit v, bit we, int bank);
    m_valid[m] = v;
    m_we[m] = we;
    m_addr[m*AW +: AW] = AW'((m << 12) | (bank << BLSB) | m | (($urandom % 4) << 8));
  endtask

  task automatic model_eval();
    bit hold [NB];
    for (int b = 0; b < NB; b++) hold[b] = ov[b] && b_lock[b];
    e_rdy = '0; e_rw = '0; e_rv = '0;
    for (int b = 0; b < NB; b++) begin
      bit found = 0;
      int pick = ptr[b];
      for (int k = 0; k < NM; k++) begin
        int idx = (ptr[b] + k) % NM;
        bit blk = 0;
        for (int b2 = 0; b2 < NB; b2++)
          if (b2 != b && hold[b2] && own[b2] == idx) blk = 1;
        if (!found && m_valid[idx] && mb(idx) == b && !blk) begin
          found = 1;
          pick = idx;
        end
      end
      g[b]  = hold[b] ? own[b] : pick;
      gv[b] = hold[b] || found;
      ef[b] = gv[b] && m_valid[g[b]] && mb(g[b]) == b;
      if (ef[b] && b_ready[b]) e_rdy[g[b]] = 1'b1;
      if (gv[b]) begin
        e_rw[g[b]] = e_rw[g[b]] | b_wdata_ready[b];
        e_rv[g[b]] = e_rv[g[b]] | b_rdata_valid[b];
      end
    end
  endtask

  task automatic settle();
    #1;
    model_eval();
    for (int b = 0; b < NB; b++) begin
      chk("R2 b_valid", 64'(b_valid[b]), 64'(ef[b]));
      if (ef[b]) begin
        chk("R1 b_addr", 64'(b_addr[b*AW +: AW]), 64'(m_addr[g[b]*AW +: AW]));
        chk("R1 b_we", 64'(b_we[b]), 64'(m_we[g[b]]));
      end
    end
    chk("R7 m_ready", 64'(m_ready), 64'(e_rdy));
    chk("R8 m_wdata_ready", 64'(m_wdata_ready), 64'(hw[LAT-1]));
    chk("R8 m_rdata_valid", 64'(m_rdata_valid), 64'(hr[LAT-1]));
  endtask

  task automatic adv();
    @(posedge clk);
    for (int b = 0; b < NB; b++) begin
      own[b] = g[b];
      ov[b]  = gv[b];
      if (ef[b] && b_ready[b]) ptr[b] = (g[b] + 1) % NM;
    end
    for (int i = LAT-1; i > 0; i--) begin
      hw[i] = hw[i-1];
      hr[i] = hr[i-1];
    end
    hw[0] = e_rw;
    hr[0] = e_rv;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog (all requirements): actual hung, expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int b = 0; b < NB; b++) begin own[b] = 0; ptr[b] = 0; ov[b] = 0; end
    for (int i = 0; i < LAT; i++) begin hw[i] = '0; hr[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state, no requests
    settle();
    chk("R9 b_valid idle", 64'(b_valid), 64'h0);
    chk("R9 m_ready idle", 64'(m_ready), 64'h0);
    chk("R9 strobes idle", 64'({m_wdata_ready, m_rdata_valid}), 64'h0);
    adv();

    // R2: addresses present but no valid
    for (int m = 0; m < NM; m++) set_req(m, 0, 0, 0);
    b_ready = '1;
    settle();
    chk("R2 invalid not granted", 64'(b_valid[0]), 64'h0);
    adv();

    // R5: four masters on bank 2 rotate 0,1,2,3,0
    for (int m = 0; m < NM; m++) set_req(m, 1, m[0], 2);
    for (int s = 0; s < 5; s++) begin
      settle();
      chk("R5 rotation", 64'(m_ready), 64'(1 << (s % NM)));
      adv();
    end

    // R6: stall keeps master 1, then accepts it
    b_ready = '0;
    for (int s = 0; s < 3; s++) begin
      settle();
      chk("R6 stall no ready", 64'(m_ready), 64'h0);
      chk("R6 stall same master", 64'(b_addr[2*AW +: AW]), 64'(m_addr[1*AW +: AW]));
      adv();
    end
    b_ready = '1;
    settle();
    chk("R6 accept after stall", 64'(m_ready), 64'h2);
    adv();

    // R3, R4, R8: lock on bank 3 holding master 1
    m_valid = '0;
    set_req(1, 1, 1, 3);
    settle();
    chk("R4 initial grant", 64'(m_ready), 64'h2);
    adv();
    b_lock[3] = 1'b1;
    set_req(1, 1, 0, 5);
    set_req(2, 1, 0, 3);
    settle();
    chk("R3 held master excluded", 64'(b_valid[5]), 64'h0);
    chk("R4 other master waits", 64'(m_ready), 64'h0);
    adv();
    b_wdata_ready[3] = 1'b1;
    settle();
    adv();
    b_wdata_ready[3] = 1'b0;
    for (int s = 0; s < LAT; s++) begin
      settle();
      if (s == LAT-1) chk("R8 delayed strobe", 64'(m_wdata_ready), 64'h2);
      adv();
    end
    b_lock[3] = 1'b0;
    settle();
    chk("R4 release regrants", 64'(m_ready), 64'h6);
    chk("R3 released master to bank5", 64'(b_valid[5]), 64'h1);
    adv();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      for (int m = 0; m < NM; m++)
        set_req(m, ($urandom % 4) != 0, $urandom % 2,
                (($urandom % 8) == 0) ? int'($urandom % NB) : int'($urandom % 4));
      for (int b = 0; b < NB; b++) begin
        b_ready[b]       = ($urandom % 4) != 0;
        b_lock[b]        = ($urandom % 3) == 0;
        b_wdata_ready[b] = ($urandom % 4) == 0;
        b_rdata_valid[b] = ($urandom % 4) == 0;
      end
      settle();
      adv();
    end
    finish_run();
  end
endmodule